// File: doc/BRIEF.md
# Staged Crosspoint Routing Configuration Register

This block holds the routing setup for a crosspoint with sixteen outputs and sixteen inputs. For each output it keeps two copies of a route entry. The staged copy is written over a parallel load port. The live copy drives that output's input-select and enable lines. A route entry is a 4-bit input number plus one enable bit. A separate active-low commit strobe copies the staged entries onto the live ones. Host software can therefore stage new routes for any set of outputs and then switch all of them in the same clock cycle.

All inputs are synchronous to `clk`. A load happens when the load strobe `ld_clk` is seen falling, that is, high at one rising edge of `clk` and low at the next. The load is accepted only when the port is in parallel mode and the chip select is active. The active-low reset turns every live output off. It leaves the staged entries untouched. The staged entries come up holding unknown data, so every output should be staged before the first commit.

Top module: `xbar_cfg_regs`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first commit, every `route_en` bit and every `route_sel` field reads 0.
- R2: A load is accepted only on a falling edge of `ld_clk` (sampled high at one `clk` edge and low at the next). Holding `ld_clk` low with changing address or data writes nothing more.
- R3: While `upd_n` is high, accepted loads change only the staged entries. `route_sel` and `route_en` do not move.
- R4: Each `clk` edge that samples `upd_n` low copies all sixteen staged entries onto the live outputs at once. The outputs show the result one cycle after `upd_n` is applied.
- R5: When a load is accepted on a cycle that also samples `upd_n` low, the new entry reaches the addressed live output at that same edge.
- R6: `addr` selects the output index. `din[3:0]` is the input number and `din[4]` is the output enable. Output k uses `route_sel[4k+3:4k]` and `route_en[k]`.
- R7: An output whose enable is 0 drives `route_sel` 0 for its field, whatever input number was loaded with it.
- R8: Reset does not clear the staged entries. A commit after reset is released restores the entries that were staged before the reset.
- R9: Falling edges of `ld_clk` are ignored while `ce_n` is high or `par_mode` is low. A later commit shows the staged entry was not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the live enables |
| par_mode | input | 1 | 1 selects the parallel load port |
| ce_n | input | 1 | Active-low chip select for loads |
| ld_clk | input | 1 | Load strobe; its falling edge captures a load |
| upd_n | input | 1 | Active-low commit of staged entries to live outputs |
| addr | input | 4 | Output index being loaded |
| din | input | 5 | Bit 4 enable, bits 3:0 input number |
| route_sel | output | 64 | Input number per output, 4 bits each, zero when disabled |
| route_en | output | 16 | Live enable per output |

## Verification
A load and a commit can land on the same clock edge. In that case the addressed output must take the newly loaded entry, while every other output takes its staged entry. The bench provokes this by dropping `ld_clk` with `upd_n` already low. The scoreboard then expects the new value on that output one cycle later. Reset and a pending staged entry also meet. An entry is staged, reset is pulsed, and a commit follows; the bench expects that entry to appear rather than zeros.

// File: rtl/xbar_cfg_pkg.sv
package xbar_cfg_pkg;
    localparam int SEL_W = 4;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
    } route_t;

    typedef struct packed {
        logic ld_prev;
    } ldet_t;
endpackage

// File: rtl/xbar_load_decode.sv
module xbar_load_decode
    import xbar_cfg_pkg::*;
#(
    parameter int N_OUT  = 16,
    parameter int ADDR_W = $clog2(N_OUT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_clk,
    input  logic              ce_n,
    input  logic              par_mode,
    input  logic [ADDR_W-1:0] addr,
    output logic [N_OUT-1:0]  wr_vec
);
    ldet_t st_d, st_q;
    logic  fall, accept;

    always_comb begin
        st_d.ld_prev = ld_clk;
        fall         = st_q.ld_prev & ~ld_clk;
        accept       = fall & par_mode & ~ce_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < N_OUT; i++) begin : g_dec
        assign wr_vec[i] = accept && (addr == ADDR_W'(i));
    end

    // R6: a load addresses at most one output
    p_one_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_vec));

    // R9: deselected or serial-mode strobes write nothing
    p_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || !par_mode) |-> (wr_vec == '0));

    // R2: a write needs ld_clk high last cycle and low now
    p_edge_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vec != '0) |-> ($past(ld_clk) && !ld_clk));
endmodule

// File: rtl/xbar_cfg_slot.sv
module xbar_cfg_slot
    import xbar_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  route_t           wr_data,
    input  logic             commit,
    output logic [SEL_W-1:0] out_sel,
    output logic             out_en
);
    route_t pend_d, pend_q;
    route_t act_d, act_q;

    always_comb begin
        pend_d = wr_en  ? wr_data : pend_q;
        act_d  = commit ? pend_d  : act_q;
    end

    // staged entry deliberately has no reset
    always_ff @(posedge clk) begin
        pend_q <= pend_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

    assign out_en  = act_q.en;
    assign out_sel = act_q.en ? act_q.sel : '0;

    // R3: live entry holds without a commit
    p_live_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(act_q));

    // R4: plain commit copies the staged entry
    p_commit_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !wr_en) |=> (act_q == $past(pend_q)));

    // R5: load during commit writes straight through
    p_write_thru_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && wr_en) |=> (act_q == $past(wr_data)));

    // R8: staged entry only changes on a write
    p_stage_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pend_q));
endmodule

// File: rtl/xbar_cfg_regs.sv
module xbar_cfg_regs
    import xbar_cfg_pkg::*;
#(
    parameter int N_OUT = 16,
    localparam int ADDR_W = $clog2(N_OUT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   par_mode,
    input  logic                   ce_n,
    input  logic                   ld_clk,
    input  logic                   upd_n,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [SEL_W:0]         din,
    output logic [N_OUT*SEL_W-1:0] route_sel,
    output logic [N_OUT-1:0]       route_en
);
    logic [N_OUT-1:0] wr_vec;
    route_t           wr_data;
    logic             commit;

    assign wr_data = route_t'(din);
    assign commit  = ~upd_n;

    xbar_load_decode #(.N_OUT(N_OUT), .ADDR_W(ADDR_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_clk   (ld_clk),
        .ce_n     (ce_n),
        .par_mode (par_mode),
        .addr     (addr),
        .wr_vec   (wr_vec)
    );

    for (genvar k = 0; k < N_OUT; k++) begin : g_slot
        xbar_cfg_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_vec[k]),
            .wr_data (wr_data),
            .commit  (commit),
            .out_sel (route_sel[k*SEL_W +: SEL_W]),
            .out_en  (route_en[k])
        );
    end

    // R1: live outputs are all off while reset is held
    p_reset_off_r1: assert property (@(posedge clk)
        !rst_n |-> (route_en == '0));
endmodule

// File: tb/xbar_cfg_regs_tb_top.sv
module xbar_cfg_regs_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0, par_mode = 1'b1, ce_n = 1'b0;
    logic       ld_clk = 1'b1, upd_n = 1'b1;
    logic [3:0] addr = '0;
    logic [4:0] din  = '0;
    logic [63:0] route_sel;
    logic [15:0] route_en;

    xbar_cfg_regs dut_i (
        .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .ce_n(ce_n),
        .ld_clk(ld_clk), .upd_n(upd_n), .addr(addr), .din(din),
        .route_sel(route_sel), .route_en(route_en)
    );

    typedef struct {
        int          due;
        string       tag;
        logic [63:0] sel;
        logic [15:0] en;
    } exp_t;

    exp_t       q[$];
    logic [4:0] m_pend[16];
    logic [4:0] m_act[16];
    logic       m_prev_ld = 1'b0;
    int         cyc = 0, total = 0, bad = 0;
    bit         done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare every expectation that falls due this cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (route_sel !== e.sel || route_en !== e.en) begin
                bad++;
                $display("FAIL %s @%0d: sel=%h en=%h expected sel=%h en=%h",
                         e.tag, cyc, route_sel, route_en, e.sel, e.en);
            end
        end
    end

    task automatic push(input string tag);
        exp_t e;
        e.due = cyc + 1;
        e.tag = tag;
        for (int k = 0; k < 16; k++) begin
            e.en[k]          = m_act[k][4];
            e.sel[k*4 +: 4]  = m_act[k][4] ? m_act[k][3:0] : 4'h0;
        end
        q.push_back(e);
    endtask

    task automatic drive(input logic rs, input logic pm, input logic ce,
                         input logic ld, input logic up, input logic [3:0] a,
                         input logic [4:0] d, input string tag);
        @(negedge clk);
        rst_n = rs; par_mode = pm; ce_n = ce; ld_clk = ld; upd_n = up;
        addr = a; din = d;
        if (!rs) begin
            for (int k = 0; k < 16; k++) m_act[k] = 5'b0;
            m_prev_ld = 1'b0;
        end else begin
            if (m_prev_ld && !ld && pm && !ce) m_pend[a] = d;
            if (!up) for (int k = 0; k < 16; k++) m_act[k] = m_pend[k];
            m_prev_ld = ld;
        end
        push(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) drive(1, 1, 0, 1, 1, 4'h0, 5'h0, tag);
    endtask

    task automatic load(input logic [3:0] a, input logic [4:0] d, input logic up,
                        input logic pm, input logic ce, input string tag);
        drive(1, pm, ce, 0, up, a, d, tag);
        drive(1, pm, ce, 1, up, a, d, tag);
    endtask

    initial begin
        for (int k = 0; k < 16; k++) begin
            m_act[k]  = 5'b0;
            m_pend[k] = 5'bx;
        end
        // R1: reset held, then released with nothing committed
        for (int i = 0; i < 3; i++) drive(0, 1, 0, 1, 1, 4'h0, 5'h0, "R1");
        idle(2, "R1");
        // R3 R6: stage every output, live side stays off
        for (int i = 0; i < 16; i++) begin
            logic [4:0] d;
            d = (i % 5 == 0) ? {1'b0, 4'(i) ^ 4'hA} : {1'b1, 4'(15 - i)};
            load(4'(i), d, 1, 1, 0, "R3");
        end
        idle(2, "R3");
        // R4 R6 R7: commit all staged entries together
        drive(1, 1, 0, 1, 0, 4'h0, 5'h0, "R4_R6_R7");
        idle(2, "R4");
        // R5: load during a held commit writes through
        drive(1, 1, 0, 0, 0, 4'h3, 5'b10111, "R5");
        drive(1, 1, 0, 1, 1, 4'h3, 5'b10111, "R5");
        idle(1, "R5");
        // R9: deselected and serial-mode strobes ignored
        load(4'h4, 5'b11111, 1, 1, 1, "R9");
        load(4'h5, 5'b11111, 1, 0, 0, "R9");
        // R2: ld_clk falls while deselected, then stays low with select active
        drive(1, 1, 1, 0, 1, 4'h7, 5'b11110, "R2");
        drive(1, 1, 0, 0, 1, 4'h8, 5'b11101, "R2");
        drive(1, 1, 0, 0, 1, 4'h9, 5'b11100, "R2");
        drive(1, 1, 0, 1, 1, 4'h9, 5'b11100, "R2");
        drive(1, 1, 0, 1, 0, 4'h0, 5'h0, "R9_R2");
        idle(1, "R9");
        // R7: disabled entry with nonzero select bits
        load(4'h1, 5'b01110, 1, 1, 0, "R7");
        drive(1, 1, 0, 1, 0, 4'h0, 5'h0, "R7");
        idle(1, "R7");
        // R8: stage, reset, then commit restores staged data
        load(4'hB, 5'b11100, 1, 1, 0, "R8");
        for (int i = 0; i < 2; i++) drive(0, 1, 0, 1, 1, 4'h0, 5'h0, "R1");
        idle(2, "R1");
        drive(1, 1, 0, 1, 0, 4'h0, 5'h0, "R8");
        idle(3, "R8");
        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule